// File: doc/BRIEF.md
# Status Register and Write-Protect Controller

This block sits behind the serial front end of a small nonvolatile memory. It holds the 8-bit status and control register and decides whether each write request from the host may go ahead. When a write is accepted it times the self-timed internal write cycle. The front end passes in decoded command strobes: write-enable, write-disable, the start and the end of a status-register write, an array or identification-page write request with its address, and the end of a read. It also passes the active-low write-protect pin. The block replies one clock later with a grant or a deny pulse. For memory writes it also sends a commit strobe to the storage array.

The register fields are WPEN (bit 7), IPL (bit 6), a constant zero (bit 5), LIP (bit 4), BP1:BP0 (bits 3:2), WEL (bit 1) and RDY (bit 0). The front end reads this layout directly, so these positions are fixed. The full value, RDY included, is always present on `status`, and the front end serves status reads from it at any time. The write-cycle length is counted in system clocks and set by the parameter `CYCLE_CLKS`. Bits that would be nonvolatile in silicon are modelled as ordinary reset flops.

Top module: `wp_status_ctrl`

## Requirements
- R1: After reset `status` is 0x00, `busy` is 0, and none of `wr_grant`, `wr_deny` or `mem_commit` is pulsing.
- R2: Register layout: bit 7 WPEN, bit 6 IPL, bit 5 always 0, bit 4 LIP, bits 3:2 BP1:BP0, bit 1 WEL, bit 0 RDY, and RDY equals `busy`.
- R3: A `wren_stb` sets WEL. A `wrdi_stb` clears WEL. Each change shows on `status` one clock after the strobe.
- R4: While WEL is 0, every array write request and every status write is answered with `wr_deny` and changes nothing.
- R5: An accepted request gives `wr_grant` one clock later. For a memory write, `mem_commit` pulses in that same cycle. `busy` then stays high for exactly `CYCLE_CLKS` clocks, starting with the grant cycle. WEL clears in the clock where `busy` falls.
- R6: While `busy` is high, write, status-write, enable, disable and read-done strobes are ignored. They cause no grant and no deny, and they leave the register unchanged.
- R7: BP1:BP0 protects addresses as follows: 00 protects none, 01 protects the top quarter (0x3000–0x3FFF), 10 protects the top half (0x2000–0x3FFF), and 11 protects all of the array. A write to a protected address is denied.
- R8: A granted status write copies `sr_data` bits 7, 4, 3 and 2, and bit 6 under R10, into the register. When WPEN is 1 and `wp_n` is 0, status writes are denied, but array writes to unprotected addresses are still granted.
- R9: When WPEN is 1, a fall of `wp_n` between `sr_start` and `sr_req` cancels that status write. It is then denied and changes nothing.
- R10: A status write whose data has both bit 6 and bit 4 set leaves IPL and LIP unchanged. The other writable bits are still updated.
- R11: IPL clears when `rd_done` pulses or when any write request arrives.
- R12: A write with `wr_idpage`=1 is denied when LIP is 1 or BP1:BP0 is 11. LIP cannot be cleared once it has been set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, active low, synchronous to clk |
| wren_stb | input | 1 | Write-enable command strobe |
| wrdi_stb | input | 1 | Write-disable command strobe |
| wr_req | input | 1 | Array or identification-page write request |
| wr_addr | input | ADDR_W | Target address of the write |
| wr_idpage | input | 1 | 1 selects the identification page as target |
| sr_start | input | 1 | Status-write opcode has been decoded |
| sr_req | input | 1 | Status-write completion, with data |
| sr_data | input | 8 | New status-register value |
| rd_done | input | 1 | A read access has ended |
| wr_grant | output | 1 | Request accepted (one-clock pulse) |
| wr_deny | output | 1 | Request refused (one-clock pulse) |
| mem_commit | output | 1 | Commit strobe to the storage array |
| busy | output | 1 | Internal write cycle in progress |
| status | output | 8 | Current status register value |

## Verification
A wrong WEL or block-protect field shows up at the next write request as a grant where a deny is due, or a deny where a grant is due. It is also visible on `status` one clock after the command that should have changed it. A timer that is off by one moves the fall of `busy`, and with it the auto-clear of WEL, by one clock. The bench therefore counts the busy cycles of every granted write exactly. A stale write-cancel flag or a wrong IPL/LIP rule stays hidden until a status write completes. It is then caught by reading `status` once the cycle has ended.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
   // Status register bit positions (front end decodes these)
   localparam int SR_WPEN = 7;
   localparam int SR_IPL  = 6;
   localparam int SR_ZERO = 5;
   localparam int SR_LIP  = 4;
   localparam int SR_BP1  = 3;
   localparam int SR_BP0  = 2;
   localparam int SR_WEL  = 1;
   localparam int SR_RDY  = 0;

   typedef struct packed {
      logic       wpen;
      logic       ipl;
      logic       zero;
      logic       lip;
      logic [1:0] bp;
      logic       wel;
      logic       rdy;
   } status_t;

   typedef enum logic [1:0] {
      PROT_NONE    = 2'b00,
      PROT_QUARTER = 2'b01,
      PROT_HALF    = 2'b10,
      PROT_ALL     = 2'b11
   } prot_e;
endpackage

// File: rtl/wpc_prot_decode.sv
module wpc_prot_decode
   import wpc_pkg::*;
#(
   parameter int ADDR_W = 14
) (
   input  logic [1:0]        bp,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int MSB = ADDR_W - 1;

   if (ADDR_W < 2) begin : g_bad_width
      $error("wpc_prot_decode: ADDR_W must be at least 2");
   end

   always_comb begin
      unique case (prot_e'(bp))
         PROT_NONE:    hit = 1'b0;
         PROT_QUARTER: hit = addr[MSB] & addr[MSB-1];
         PROT_HALF:    hit = addr[MSB];
         default:      hit = 1'b1;
      endcase
   end
endmodule

// File: rtl/wpc_cycle_timer.sv
module wpc_cycle_timer #(
   parameter int CYCLE_CLKS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CNT_W = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLE_CLKS - 1);

   if (CYCLE_CLKS < 1) begin : g_bad_len
      $error("wpc_cycle_timer: CYCLE_CLKS must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   assign done = busy && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         cnt  <= LOAD;
      end else if (done) begin
         busy <= 1'b0;
      end else if (busy) begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl
   import wpc_pkg::*;
#(
   parameter int ADDR_W     = 14,
   parameter int CYCLE_CLKS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_n,
   input  logic              wren_stb,
   input  logic              wrdi_stb,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_idpage,
   input  logic              sr_start,
   input  logic              sr_req,
   input  logic [7:0]        sr_data,
   input  logic              rd_done,
   output logic              wr_grant,
   output logic              wr_deny,
   output logic              mem_commit,
   output logic              busy,
   output logic [7:0]        status
);
   status_t sr_q;
   logic    wp_q, sr_pend, cyc_done;
   logic    accept, prot_hit, hw_lock, wp_fall;
   logic    wr_ok, wr_no, sr_ok, sr_no, both_id;

   wpc_prot_decode #(.ADDR_W(ADDR_W)) u_prot (
      .bp   (sr_q.bp),
      .addr (wr_addr),
      .hit  (prot_hit)
   );

   wpc_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wr_ok | sr_ok),
      .busy  (busy),
      .done  (cyc_done)
   );

   assign accept  = !busy;
   assign hw_lock = sr_q.wpen && !wp_n;
   assign wp_fall = wp_q && !wp_n;
   assign both_id = sr_data[SR_IPL] && sr_data[SR_LIP];

   always_comb begin
      wr_ok = 1'b0;
      if (wr_req && accept && sr_q.wel) begin
         if (wr_idpage) wr_ok = !sr_q.lip && (sr_q.bp != 2'b11);
         else           wr_ok = !prot_hit;
      end
      wr_no = wr_req && accept && !wr_ok;
      sr_ok = sr_req && accept && sr_pend && sr_q.wel && !hw_lock;
      sr_no = sr_req && accept && !sr_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q       <= '0;
         wp_q       <= 1'b1;
         sr_pend    <= 1'b0;
         wr_grant   <= 1'b0;
         wr_deny    <= 1'b0;
         mem_commit <= 1'b0;
      end else begin
         wp_q       <= wp_n;
         wr_grant   <= wr_ok | sr_ok;
         wr_deny    <= wr_no | sr_no;
         mem_commit <= wr_ok;

         if (sr_req || (sr_q.wpen && wp_fall)) sr_pend <= 1'b0;
         else if (sr_start && accept)          sr_pend <= 1'b1;

         if (cyc_done || (wrdi_stb && accept)) sr_q.wel <= 1'b0;
         else if (wren_stb && accept)          sr_q.wel <= 1'b1;

         if (accept && (rd_done || wr_req)) sr_q.ipl <= 1'b0;

         if (sr_ok) begin
            sr_q.wpen <= sr_data[SR_WPEN];
            sr_q.bp   <= sr_data[SR_BP1:SR_BP0];
            if (!both_id) begin
               sr_q.ipl <= sr_data[SR_IPL];
               sr_q.lip <= sr_q.lip | sr_data[SR_LIP];
            end
         end
      end
   end

   always_comb begin
      status          = sr_q;
      status[SR_ZERO] = 1'b0;
      status[SR_RDY]  = busy;
   end
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
   parameter int ADDR_W     = 14,
   parameter int CYCLE_CLKS = 32
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_req,
   input logic       sr_req,
   input logic       wr_grant,
   input logic       wr_deny,
   input logic       mem_commit,
   input logic       busy,
   input logic [7:0] status
);
   localparam int BW = $clog2(CYCLE_CLKS + 2);
   logic [BW-1:0] bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bcnt <= '0;
      else if (busy) bcnt <= bcnt + 1'b1;
      else           bcnt <= '0;
   end

   assert_bit5_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      status[5] == 1'b0);
   assert_rdy_is_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      status[0] == busy);
   assert_no_grant_and_deny_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_grant && wr_deny));
   assert_commit_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_commit |-> (busy && wr_grant));
   assert_busy_from_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> wr_grant);
   assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (bcnt == BW'(CYCLE_CLKS)));
   assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bcnt < BW'(CYCLE_CLKS)));
   assert_wel_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !status[1]);
   assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (wr_req || sr_req)) |=> (!wr_grant && !wr_deny));
   assert_ipl_lip_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !($rose(status[6]) && $rose(status[4])));
   assert_lip_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[4]) |-> 1'b0);
endmodule

bind wp_status_ctrl wpc_checker #(.ADDR_W(ADDR_W), .CYCLE_CLKS(CYCLE_CLKS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_req     (wr_req),
   .sr_req     (sr_req),
   .wr_grant   (wr_grant),
   .wr_deny    (wr_deny),
   .mem_commit (mem_commit),
   .busy       (busy),
   .status     (status)
);

// File: tb/wp_status_ctrl_bench.sv
module wp_status_ctrl_bench;
   localparam int ADDR_W = 14;
   localparam int CYC    = 32;

   logic clk = 1'b0, rst_n = 1'b0, wp_n = 1'b1;
   logic wren_stb = 0, wrdi_stb = 0, wr_req = 0, wr_idpage = 0;
   logic sr_start = 0, sr_req = 0, rd_done = 0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [7:0] sr_data = '0;
   logic wr_grant, wr_deny, mem_commit, busy;
   logic [7:0] status;
   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   wp_status_ctrl #(.ADDR_W(ADDR_W), .CYCLE_CLKS(CYC)) u_wp_status_ctrl (
      .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_idpage(wr_idpage), .sr_start(sr_start),
      .sr_req(sr_req), .sr_data(sr_data), .rd_done(rd_done), .wr_grant(wr_grant),
      .wr_deny(wr_deny), .mem_commit(mem_commit), .busy(busy), .status(status));

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic tick; @(negedge clk); endtask

   task automatic wren;  wren_stb = 1; tick; wren_stb = 0; endtask
   task automatic wrdi;  wrdi_stb = 1; tick; wrdi_stb = 0; endtask
   task automatic rdone; rd_done  = 1; tick; rd_done  = 0; endtask

   // write request; afterwards {grant,deny,commit} is visible
   task automatic wreq(logic [ADDR_W-1:0] a, logic idp);
      wr_addr = a; wr_idpage = idp; wr_req = 1; tick; wr_req = 0; wr_idpage = 0;
   endtask

   task automatic wait_idle;
      for (int i = 0; i < CYC + 4 && busy; i++) tick;
   endtask

   task automatic srwrite(logic [7:0] d, logic exp_grant, string req);
      wren;
      sr_start = 1; tick; sr_start = 0;
      sr_data = d; sr_req = 1; tick; sr_req = 0;
      chk(req, {wr_grant, wr_deny}, exp_grant ? 2'b10 : 2'b01);
      wait_idle;
   endtask

   task automatic t_reset;
      chk("R1 status", status, 8'h00);
      chk("R1 strobes", {busy, wr_grant, wr_deny, mem_commit}, 4'b0000);
   endtask

   task automatic t_wel_needed;
      wreq(14'h0100, 0);
      chk("R4 array write without WEL", {wr_grant, wr_deny, mem_commit}, 3'b010);
      sr_start = 1; tick; sr_start = 0;
      sr_data = 8'h8C; sr_req = 1; tick; sr_req = 0;
      chk("R4 status write without WEL", {wr_grant, wr_deny}, 2'b01);
      chk("R4 status unchanged", status, 8'h00);
   endtask

   task automatic t_wren_wrdi;
      wren; chk("R3 WEL set", status, 8'h02);
      wrdi; chk("R3 WEL clear", status, 8'h00);
   endtask

   task automatic t_write_cycle;
      int n;
      wren;
      wreq(14'h0100, 0);
      chk("R5 grant+commit", {wr_grant, wr_deny, mem_commit}, 3'b101);
      chk("R2 RDY and WEL during cycle", status, 8'h03);
      n = 1;
      for (int i = 0; i < CYC + 4; i++) begin
         tick;
         if (busy) n++; else break;
      end
      chk("R5 busy length", n, CYC);
      chk("R5 WEL auto clear", status, 8'h00);
   endtask

   task automatic t_busy_ignore;
      wren; wreq(14'h0000, 0);
      wrdi;
      chk("R6 WRDI ignored while busy", status, 8'h03);
      wreq(14'h0004, 0);
      chk("R6 write ignored while busy", {wr_grant, wr_deny, mem_commit}, 3'b000);
      sr_start = 1; tick; sr_start = 0;
      sr_data = 8'h0C; sr_req = 1; tick; sr_req = 0;
      chk("R6 status write ignored while busy", {wr_grant, wr_deny}, 2'b00);
      chk("R6 register unchanged", status, 8'h03);
      wait_idle;
   endtask

   task automatic t_block(logic [1:0] bp, logic [ADDR_W-1:0] a_bad, logic [ADDR_W-1:0] a_ok);
      srwrite({4'b0000, bp, 2'b00}, 1, "R8 set BP");
      chk("R8 BP field", status, {4'b0000, bp, 2'b00});
      wren;
      wreq(a_bad, 0);
      chk("R7 protected address denied", {wr_grant, wr_deny}, 2'b01);
      if (bp != 2'b11) begin
         wreq(a_ok, 0);
         chk("R7 unprotected address granted", {wr_grant, wr_deny, mem_commit}, 3'b101);
         wait_idle;
      end else wrdi;
   endtask

   task automatic t_ipl_lip_both;
      srwrite(8'h5C, 1, "R10 both set still granted");
      chk("R10 IPL/LIP unchanged, BP written", status, 8'h0C);
      srwrite(8'h00, 1, "R10 clear BP");
   endtask

   task automatic t_ipl;
      srwrite(8'h40, 1, "R11 set IPL");
      chk("R11 IPL set", status, 8'h40);
      rdone;
      chk("R11 IPL cleared by read end", status, 8'h00);
      srwrite(8'h40, 1, "R11 set IPL again");
      wren;
      wreq(14'h3F05, 1);
      chk("R12 id page write granted", {wr_grant, wr_deny, mem_commit}, 3'b101);
      chk("R11 IPL cleared by write", status[6], 0);
      wait_idle;
      srwrite(8'h4C, 1, "R12 IPL with BP=11");
      wren;
      wreq(14'h0001, 1);
      chk("R12 id page write denied at BP=11", {wr_grant, wr_deny}, 2'b01);
      wrdi;
      srwrite(8'h00, 1, "R12 clear BP");
   endtask

   task automatic t_hw_prot;
      srwrite(8'h84, 1, "R8 set WPEN");
      wp_n = 0; tick;
      srwrite(8'h00, 0, "R8 status write denied by pin");
      chk("R8 register held under pin lock", status, 8'h86);
      wreq(14'h0010, 0);
      chk("R8 array write allowed under pin lock", {wr_grant, wr_deny, mem_commit}, 3'b101);
      wait_idle;
      chk("R8 after cycle", status, 8'h84);
      wp_n = 1; tick;
      wren;
      sr_start = 1; tick; sr_start = 0;
      wp_n = 0; tick; wp_n = 1; tick;
      sr_data = 8'h00; sr_req = 1; tick; sr_req = 0;
      chk("R9 cancelled status write denied", {wr_grant, wr_deny}, 2'b01);
      chk("R9 register unchanged", status, 8'h86);
      wrdi;
      srwrite(8'h00, 1, "R9 uncancelled status write");
      chk("R9 WPEN cleared", status, 8'h00);
   endtask

   task automatic t_lip;
      srwrite(8'h10, 1, "R12 set LIP");
      chk("R12 LIP set", status, 8'h10);
      srwrite(8'h00, 1, "R12 try clear LIP");
      chk("R12 LIP sticky", status, 8'h10);
      srwrite(8'h40, 1, "R12 IPL with LIP");
      wren;
      wreq(14'h0002, 1);
      chk("R12 locked id page denied", {wr_grant, wr_deny, mem_commit}, 3'b010);
   endtask

   initial begin
      fork
         begin
            repeat (3) tick;
            rst_n = 1; tick;
            t_reset;
            t_wel_needed;
            t_wren_wrdi;
            t_write_cycle;
            t_busy_ignore;
            t_block(2'b01, 14'h3000, 14'h2FFF);
            t_block(2'b10, 14'h2000, 14'h1FFF);
            t_block(2'b11, 14'h0000, 14'h0000);
            srwrite(8'h00, 1, "R7 clear BP");
            t_ipl_lip_both;
            t_ipl;
            t_hw_prot;
            t_lip;
         end
         begin
            repeat (20000) tick;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule